// File: doc/BRIEF.md
# Tagged Read Request Splitter

This block accepts one read transfer, given as a contiguous source address, a local destination address and a length in dwords. It cuts the transfer into memory read requests. No request is longer than a programmable maximum request size. Each request is issued with a tag that is not in use at the time. A small tag table holds, for each outstanding tag, the local address where its data goes next and the number of dwords still due.

Completion beats carry one dword and a tag, and they may come back in any order across tags. The block looks up the tag's entry, writes the dword through its local write port to that address, and moves the entry forward. When every dword of a tag has arrived, the tag is freed for reuse. When the whole transfer has been requested and every tag has been freed, the block raises a one-cycle done pulse and becomes ready for the next transfer.

Top module: `rdreq_split`

## Requirements
- R1: A transfer is accepted in a cycle where `xfer_valid` and `xfer_ready` are both high. `xfer_ready` stays low from the cycle after acceptance until the done pulse. The length must be at least one dword.
- R2: `mrrs_sel` is sampled at acceptance. Value 0 selects 128 bytes (32 dwords), 1 selects 256 bytes (64), 2 selects 512 bytes (128) and 3 selects 1024 bytes (256). No request has a length of zero or above the selected size.
- R3: Requests cover the source in ascending order. The first request starts at `xfer_src`, and each later one starts at the previous address plus 4 times the previous length. Every request except the last carries the full maximum size. The last carries the remainder.
- R4: No issued tag is already outstanding. The lowest-numbered free tag is chosen. At most 8 tags are outstanding, and when all are in use no further request appears until one is freed.
- R5: While `req_valid` is high and `req_ready` is low, the request address, length and tag hold their values.
- R6: A completion beat on an outstanding tag produces a write one cycle later. The write address is the destination address of that tag's request plus 4 times the number of dwords already received for that tag. Beats of different tags may interleave in any order.
- R7: A tag is freed when the number of dwords received for it equals its request length. A freed tag may be given to the next request.
- R8: `done` is high for exactly one cycle, one cycle after the last tag is freed with nothing left to request. `xfer_ready` is high in that same cycle.
- R9: With the 512-byte setting, a 1024-dword (4 KB) transfer produces exactly 8 requests of 128 dwords.
- R10: A completion beat whose tag is not outstanding produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Transfer offered |
| xfer_ready | output | 1 | Block idle, transfer can be taken |
| xfer_src | input | ADDR_W | Source byte address (dword aligned) |
| xfer_dst | input | ADDR_W | Local destination byte address (dword aligned) |
| xfer_len | input | LEN_W | Transfer length in dwords |
| mrrs_sel | input | 2 | Maximum request size code |
| req_valid | output | 1 | Read request present |
| req_ready | input | 1 | Request taken by the link side |
| req_addr | output | ADDR_W | Request source byte address |
| req_len | output | LEN_W | Request length in dwords |
| req_tag | output | TAG_W | Request tag |
| cpl_valid | input | 1 | Completion beat present |
| cpl_tag | input | TAG_W | Tag of the completion beat |
| cpl_data | input | DATA_W | One dword of completion data |
| wr_valid | output | 1 | Local write strobe |
| wr_addr | output | ADDR_W | Local write byte address |
| wr_data | output | DATA_W | Local write data |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The assertions assume the link side sends completion beats only for tags it has seen on a taken request. They also assume it never sends more dwords for a tag than that request asked for, and that the beats within one tag arrive in address order. The bench keeps to these rules: it answers only from its own list of taken requests, and it counts the dwords sent for each one. It changes the order only across tags. The single stray beat for R10 goes to a tag that is free, while the block is idle.

// File: rtl/rdsplit_pkg.sv
package rdsplit_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } split_state_e;

  // Size code to dwords: 0..3 -> 32, 64, 128, 256
  function automatic int unsigned mrrs_dwords(input logic [1:0] sel);
    return 32'd32 << sel;
  endfunction

endpackage

// File: rtl/rdsplit_tagpick.sv
module rdsplit_tagpick #(
  parameter int NTAG  = 8,
  parameter int TAG_W = 3
) (
  input  logic [NTAG-1:0]  busy,
  output logic             any_free,
  output logic [TAG_W-1:0] free_tag
);

  // Lowest-numbered free slot wins
  always_comb begin
    any_free = 1'b0;
    free_tag = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        free_tag = TAG_W'(i);
      end
    end
  end

endmodule

// File: rtl/rdsplit_tagtab.sv
module rdsplit_tagtab #(
  parameter int NTAG   = 8,
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [ADDR_W-1:0] alloc_dst,
  input  logic [LEN_W-1:0]  alloc_len,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  output logic [NTAG-1:0]   busy,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam logic [ADDR_W-1:0] DW_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] next_dst [NTAG];
  logic [LEN_W-1:0]  left_dw  [NTAG];
  logic [NTAG-1:0]   busy_q;
  logic              hit;

  assign hit  = cpl_valid && busy_q[cpl_tag];
  assign busy = busy_q;

  // Entry storage: no reset, one write per entry per cycle
  always_ff @(posedge clk) begin
    for (int i = 0; i < NTAG; i++) begin
      if (alloc_en && alloc_tag == TAG_W'(i)) begin
        next_dst[i] <= alloc_dst;
        left_dw[i]  <= alloc_len;
      end else if (hit && cpl_tag == TAG_W'(i)) begin
        next_dst[i] <= next_dst[i] + DW_BYTES;
        left_dw[i]  <= left_dw[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else begin
      for (int i = 0; i < NTAG; i++) begin
        if (alloc_en && alloc_tag == TAG_W'(i)) begin
          busy_q[i] <= 1'b1;
        end else if (hit && cpl_tag == TAG_W'(i) && left_dw[i] == LEN_W'(1)) begin
          busy_q[i] <= 1'b0;
        end
      end
    end
  end

  // Registered local write port
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= hit;
    end
  end

  always_ff @(posedge clk) begin
    if (hit) begin
      wr_addr <= next_dst[cpl_tag];
      wr_data <= cpl_data;
    end
  end

endmodule

// File: rtl/rdsplit_issue.sv
module rdsplit_issue
  import rdsplit_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic [ADDR_W-1:0] xfer_src,
  input  logic [ADDR_W-1:0] xfer_dst,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [1:0]        mrrs_sel,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              any_free,
  input  logic [TAG_W-1:0]  free_tag,
  input  logic              none_busy,
  output logic              alloc_en,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic [ADDR_W-1:0] alloc_dst,
  output logic [LEN_W-1:0]  alloc_len,
  output logic [LEN_W-1:0]  max_dw,
  output logic              done
);

  split_state_e      state_q;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;
  logic [LEN_W-1:0]  remain_q;
  logic [LEN_W-1:0]  max_q;
  logic [LEN_W-1:0]  chunk;
  logic [ADDR_W-1:0] step_bytes;
  logic              slot_open;
  logic              load;
  logic              finish;

  assign chunk      = (remain_q < max_q) ? remain_q : max_q;
  assign step_bytes = ADDR_W'(chunk) << 2;
  assign slot_open  = !req_valid || req_ready;
  assign load       = (state_q == ST_RUN) && (remain_q != '0) && slot_open && any_free;
  assign finish     = (state_q == ST_RUN) && (remain_q == '0) && !req_valid && none_busy;

  assign xfer_ready = (state_q == ST_IDLE);
  assign alloc_en   = load;
  assign alloc_tag  = free_tag;
  assign alloc_dst  = dst_q;
  assign alloc_len  = chunk;
  assign max_dw     = max_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      remain_q  <= '0;
      max_q     <= LEN_W'(mrrs_dwords(2'd0));
      req_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (xfer_valid) begin
            state_q  <= ST_RUN;
            remain_q <= xfer_len;
            max_q    <= LEN_W'(mrrs_dwords(mrrs_sel));
          end
        end
        ST_RUN: begin
          if (load) begin
            req_valid <= 1'b1;
            remain_q  <= remain_q - chunk;
          end else if (req_ready) begin
            req_valid <= 1'b0;
          end
          if (finish) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Address and request payload registers (no reset needed)
  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && xfer_valid) begin
      src_q <= xfer_src;
      dst_q <= xfer_dst;
    end else if (load) begin
      src_q    <= src_q + step_bytes;
      dst_q    <= dst_q + step_bytes;
      req_addr <= src_q;
      req_len  <= chunk;
      req_tag  <= free_tag;
    end
  end

endmodule

// File: rtl/rdreq_split.sv
module rdreq_split #(
  parameter int NTAG   = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32,
  localparam int TAG_W = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic [ADDR_W-1:0] xfer_src,
  input  logic [ADDR_W-1:0] xfer_dst,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [1:0]        mrrs_sel,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);

  logic [NTAG-1:0]   busy;
  logic              any_free;
  logic [TAG_W-1:0]  free_tag;
  logic              alloc_en;
  logic [TAG_W-1:0]  alloc_tag;
  logic [ADDR_W-1:0] alloc_dst;
  logic [LEN_W-1:0]  alloc_len;
  logic [LEN_W-1:0]  max_dw;

  rdsplit_tagpick #(.NTAG(NTAG), .TAG_W(TAG_W)) u_pick (
    .busy     (busy),
    .any_free (any_free),
    .free_tag (free_tag)
  );

  rdsplit_issue #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .xfer_src   (xfer_src),
    .xfer_dst   (xfer_dst),
    .xfer_len   (xfer_len),
    .mrrs_sel   (mrrs_sel),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_tag    (req_tag),
    .any_free   (any_free),
    .free_tag   (free_tag),
    .none_busy  (busy == '0),
    .alloc_en   (alloc_en),
    .alloc_tag  (alloc_tag),
    .alloc_dst  (alloc_dst),
    .alloc_len  (alloc_len),
    .max_dw     (max_dw),
    .done       (done)
  );

  rdsplit_tagtab #(
    .NTAG(NTAG), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) u_tab (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (alloc_en),
    .alloc_tag (alloc_tag),
    .alloc_dst (alloc_dst),
    .alloc_len (alloc_len),
    .cpl_valid (cpl_valid),
    .cpl_tag   (cpl_tag),
    .cpl_data  (cpl_data),
    .busy      (busy),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

endmodule

// File: rtl/rdreq_split_chk.sv
module rdreq_split_chk #(
  parameter int NTAG   = 8,
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [TAG_W-1:0]  req_tag,
  input logic              cpl_valid,
  input logic [TAG_W-1:0]  cpl_tag,
  input logic              wr_valid,
  input logic              done,
  input logic [NTAG-1:0]   busy,
  input logic [LEN_W-1:0]  max_dw
);

  p_busy_while_req_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !xfer_ready);

  p_len_cap_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0 && req_len <= max_dw));

  p_tag_owned_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy[req_tag]);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_tag));

  p_write_follows_r6: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && busy[cpl_tag] |=> wr_valid);

  p_no_stray_write_r10: assert property (@(posedge clk) disable iff (rst)
    !(cpl_valid && busy[cpl_tag]) |=> !wr_valid);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> xfer_ready && (busy == '0) && !req_valid);

endmodule

bind rdreq_split rdreq_split_chk #(
  .NTAG(NTAG), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .xfer_ready (xfer_ready),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .req_tag    (req_tag),
  .cpl_valid  (cpl_valid),
  .cpl_tag    (cpl_tag),
  .wr_valid   (wr_valid),
  .done       (done),
  .busy       (busy),
  .max_dw     (max_dw)
);

// File: tb/sim_rdreq_split.sv
module sim_rdreq_split;

  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE_DLY = CLK_PERIOD / 4;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int DW = 32;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_valid = 1'b0;
  logic          xfer_ready;
  logic [AW-1:0] xfer_src = '0;
  logic [AW-1:0] xfer_dst = '0;
  logic [LW-1:0] xfer_len = '0;
  logic [1:0]    mrrs_sel = '0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [TW-1:0] req_tag;
  logic          cpl_valid = 1'b0;
  logic [TW-1:0] cpl_tag = '0;
  logic [DW-1:0] cpl_data = '0;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rdreq_split u0 (
    .clk(clk), .rst(rst),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len), .mrrs_sel(mrrs_sel),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done)
  );

  typedef struct { logic [AW-1:0] addr; int len; } rq_t;
  typedef struct { int tag; logic [AW-1:0] src; int len; int sent; } pd_t;

  rq_t           exp_req[$];
  pd_t           pend[$];
  logic [DW-1:0] exp_wr [logic [AW-1:0]];
  int total = 0;
  int bad = 0;
  int n_issued = 0;
  int done_cnt = 0;
  int cur_max = 32;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5a3c_0f11;
  endfunction

  // Monitor: requests, writes and done, sampled mid low phase
  always begin
    @(negedge clk);
    #(SAMPLE_DLY);
    if (!rst && req_valid && req_ready) begin
      n_issued++;
      if (exp_req.size() == 0) begin
        chk(1'b0, "R3", "unexpected request", longint'(req_addr), 0);
      end else begin
        rq_t e;
        bit clash;
        e = exp_req.pop_front();
        chk(req_addr == e.addr, "R3", "request address", longint'(req_addr), longint'(e.addr));
        chk(int'(req_len) == e.len, "R3", "request length", longint'(req_len), longint'(e.len));
        chk(int'(req_len) <= cur_max && req_len != 0, "R2", "length cap", longint'(req_len), longint'(cur_max));
        clash = 1'b0;
        foreach (pend[k]) if (pend[k].tag == int'(req_tag)) clash = 1'b1;
        chk(!clash, "R4", "tag already outstanding", longint'(req_tag), 0);
        pend.push_back('{tag: int'(req_tag), src: req_addr, len: int'(req_len), sent: 0});
      end
    end
    if (!rst && wr_valid) begin
      if (exp_wr.exists(wr_addr)) begin
        chk(wr_data == exp_wr[wr_addr], "R6", "write data", longint'(wr_data), longint'(exp_wr[wr_addr]));
        exp_wr.delete(wr_addr);
      end else begin
        chk(1'b0, "R6", "write to unexpected address", longint'(wr_addr), 0);
      end
    end
    if (!rst && done) begin
      done_cnt++;
      chk(exp_wr.size() == 0 && pend.size() == 0 && exp_req.size() == 0, "R8",
          "done before all data placed", longint'(exp_wr.size()), 0);
    end
  end

  // Driver: queue the expected requests and writes, then offer the transfer
  task automatic run_xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                          input int len, input logic [1:0] sel);
    int rem;
    logic [AW-1:0] a;
    cur_max = 32 << sel;
    rem = len;
    a = src;
    while (rem > 0) begin
      int c;
      c = (rem < cur_max) ? rem : cur_max;
      exp_req.push_back('{addr: a, len: c});
      a = a + AW'(4 * c);
      rem = rem - c;
    end
    for (int i = 0; i < len; i++) exp_wr[dst + AW'(4 * i)] = pat(src + AW'(4 * i));
    @(negedge clk);
    xfer_valid = 1'b1;
    xfer_src = src;
    xfer_dst = dst;
    xfer_len = LW'(len);
    mrrs_sel = sel;
    #(SAMPLE_DLY);
    chk(xfer_ready == 1'b1, "R1", "ready when offered", longint'(xfer_ready), 1);
    @(negedge clk);
    xfer_valid = 1'b0;
    #(SAMPLE_DLY);
    chk(xfer_ready == 1'b0, "R1", "ready after accept", longint'(xfer_ready), 0);
  endtask

  task automatic send_beats(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cpl_valid = 1'b1;
      cpl_tag = TW'(pend[idx].tag);
      cpl_data = pat(pend[idx].src + AW'(4 * pend[idx].sent));
      pend[idx].sent++;
    end
    @(negedge clk);
    cpl_valid = 1'b0;
    if (pend[idx].sent == pend[idx].len) pend.delete(idx);
  endtask

  task automatic drain_all();
    int guard;
    guard = 0;
    while ((pend.size() != 0 || exp_req.size() != 0) && guard < 5000) begin
      if (pend.size() != 0) send_beats(0, pend[0].len - pend[0].sent);
      else @(negedge clk);
      guard++;
    end
  endtask

  task automatic wait_done(input int target);
    int i;
    i = 0;
    while (done_cnt < target && i < 3000) begin
      @(negedge clk);
      i++;
    end
    chk(done_cnt == target, "R8", "done count", longint'(done_cnt), longint'(target));
    #(SAMPLE_DLY);
    chk(done == 1'b0 && xfer_ready == 1'b1, "R8", "pulse ends, ready back",
        longint'({done, xfer_ready}), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    logic [AW-1:0] h_addr;
    logic [LW-1:0] h_len;
    logic [TW-1:0] h_tag;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #(SAMPLE_DLY);
    chk(xfer_ready && !req_valid && !wr_valid && !done, "R1", "reset state",
        longint'({xfer_ready, req_valid, wr_valid, done}), 8);

    // 4 KB at 512-byte size: 8 full requests, answered last to first (R9)
    req_ready = 1'b1;
    run_xfer(32'h1000_0000, 32'h0002_0000, 1024, 2'd2);
    repeat (40) @(negedge clk);
    chk(n_issued == 8, "R9", "request count", longint'(n_issued), 8);
    chk(pend.size() == 8, "R4", "distinct outstanding tags", longint'(pend.size()), 8);
    for (int i = 7; i >= 0; i--) send_beats(i, pend[i].len);
    wait_done(1);

    // 70 dwords at 128 bytes: 32, 32, 6 with interleaved partial completions (R3, R6)
    base = n_issued;
    run_xfer(32'h3000_0040, 32'h0004_0100, 70, 2'd0);
    repeat (20) @(negedge clk);
    chk(n_issued - base == 3, "R3", "split count with remainder", longint'(n_issued - base), 3);
    send_beats(1, 5);
    send_beats(0, 7);
    send_beats(2, 6);
    send_beats(1, 27);
    send_beats(0, 25);
    wait_done(2);

    // 300 dwords at 128 bytes: 10 requests, stall at 8 tags, reuse of freed tag (R4, R7)
    base = n_issued;
    run_xfer(32'h5000_0000, 32'h0008_0000, 300, 2'd0);
    repeat (30) @(negedge clk);
    #(SAMPLE_DLY);
    chk(n_issued - base == 8, "R4", "issue stalls with all tags in use", longint'(n_issued - base), 8);
    chk(req_valid == 1'b0, "R4", "no request while tags full", longint'(req_valid), 0);
    for (int k = 0; k < 8; k++)
      chk(pend[k].tag == k, "R4", "lowest free tag order", longint'(pend[k].tag), longint'(k));
    send_beats(3, 32);
    repeat (5) @(negedge clk);
    chk(n_issued - base == 9, "R7", "issue resumes after release", longint'(n_issued - base), 9);
    chk(pend[pend.size() - 1].tag == 3, "R7", "freed tag reused", longint'(pend[pend.size() - 1].tag), 3);
    drain_all();
    wait_done(3);

    // 65 dwords at 256 bytes under backpressure (R5)
    req_ready = 1'b0;
    run_xfer(32'h7000_0000, 32'h000c_0000, 65, 2'd1);
    repeat (4) @(negedge clk);
    #(SAMPLE_DLY);
    chk(req_valid == 1'b1, "R5", "request waiting", longint'(req_valid), 1);
    h_addr = req_addr;
    h_len = req_len;
    h_tag = req_tag;
    repeat (3) @(negedge clk);
    #(SAMPLE_DLY);
    chk(req_valid && req_addr == h_addr && req_len == h_len && req_tag == h_tag, "R5",
        "request held", longint'(req_addr), longint'(h_addr));
    @(negedge clk);
    req_ready = 1'b1;
    drain_all();
    wait_done(4);

    // Largest size: one request of 256 dwords (R2)
    base = n_issued;
    run_xfer(32'h9000_0000, 32'h0010_0000, 256, 2'd3);
    repeat (10) @(negedge clk);
    chk(n_issued - base == 1, "R2", "single full-size request", longint'(n_issued - base), 1);
    drain_all();
    wait_done(5);

    // Stray beat on a free tag while idle (R10)
    @(negedge clk);
    cpl_valid = 1'b1;
    cpl_tag = 3'd5;
    cpl_data = 32'hdead_beef;
    @(negedge clk);
    cpl_valid = 1'b0;
    #(SAMPLE_DLY);
    chk(wr_valid == 1'b0, "R10", "no write for free tag", longint'(wr_valid), 0);
    repeat (5) @(negedge clk);
    chk(done_cnt == 5, "R8", "no extra done", longint'(done_cnt), 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule